// File: doc/BRIEF.md
# Sample Packing Memory Write Master

This block sits between a converter sample stream and a memory that several bus masters share. Each incoming sample is 12 bits wide. Only its upper eight bits are kept, and eight of these bytes are combined into one 64-bit bus word. The block therefore issues one write for every eight samples, so a 100 MHz sample stream needs only 12.5 MHz of 64-bit writes.

Packed words wait in a small internal FIFO. A memory-mapped master port drains the FIFO and obeys a wait-request handshake, so another master, such as a processor, can stall the block while it holds the memory. Every write lands in a window set by a base and a limit address, and the rest of the memory stays free for other masters.

A start pulse loads the window and begins a run. A mode input selects what happens when the limit is reached: the run either stops and raises a done flag, or it continues from the base again. If a finished word finds the FIFO full, the word is dropped and a sticky overflow flag is set.

Top module: `sample_pack_writer`

## Requirements
- R1: Only bits 11:4 of each accepted 12-bit sample reach the memory. Bits 3:0 have no effect on the written data.
- R2: The first sample of a group occupies write-data bits 7:0. Each later sample takes the next higher byte, so the eighth sample lands in bits 63:56.
- R3: Exactly one write is produced for every eight accepted samples. No write appears while a group is still incomplete.
- R4: Finished words wait in a FIFO of FIFO_DEPTH entries while writes are stalled, and they are written in arrival order.
- R5: After a start, the first write goes to the base address. Each accepted write moves the address up by 8.
- R6: With wrap mode off (wrap_en = 0), the write to the limit address ends the run. done is then 1, no further write is issued, and later samples are ignored until the next start.
- R7: With wrap mode on (wrap_en = 1), the write after the one to the limit address goes to the base address, and done stays 0.
- R8: While m_waitrequest is 1, m_write stays 1, and m_address and m_writedata hold their values. They change only after a cycle in which m_waitrequest is 0.
- R9: A finished word that arrives while the FIFO is full is dropped, and overflow is set to 1. overflow stays 1 until the next start clears it.
- R10: A start clears done, clears overflow, empties the FIFO, and discards any partly collected group. The first group after a start therefore contains only samples from after that start.
- R11: Every write has all eight bits of m_byteenable set to 1 (8'hFF).
- R12: After reset, m_write, done and overflow are 0. No write and no sample capture happens until the first start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | One-cycle pulse that loads the window and begins a run |
| wrap_en | input | 1 | 1: wrap to the base after the limit; 0: stop at the limit (captured at start) |
| base_addr | input | ADDR_W | Byte address of the first word of the window, 8-byte aligned (captured at start) |
| limit_addr | input | ADDR_W | Byte address of the last word of the window, 8-byte aligned and not below the base (captured at start) |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | SAMPLE_W | Converter sample |
| m_address | output | ADDR_W | Write byte address |
| m_writedata | output | DATA_W | Packed write data |
| m_write | output | 1 | Write request |
| m_byteenable | output | DATA_W/8 | Byte enables |
| m_waitrequest | input | 1 | Stall from the memory side |
| done | output | 1 | A non-wrapping run has reached its limit |
| overflow | output | 1 | Sticky flag: a word was dropped |

## Verification
The bench builds the block with FIFO_DEPTH = 4. At that depth, five held groups under a constant stall are enough to fill the FIFO and set the overflow flag, and the written words can be counted one by one. The sample and address widths keep their defaults of 12 and 32 bits, so the stimulus vectors exercise the real truncation boundary at bit 4 and the full 64-bit lane layout. A two-word window in wrap mode makes the return to the base appear after only three groups.

// File: rtl/sp_pkg.sv
// Package sp_pkg
// Shared types for the sample packing write master.
// Assumes: nothing beyond the standard language.
package sp_pkg;

    // Run state of the address window sequencer.
    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_RUN  = 2'd1,
        SEQ_DONE = 2'd2
    } seq_state_t;

endpackage

// File: rtl/sp_lane_packer.sv
// Module sp_lane_packer
// Keeps the upper KEEP_W bits of each accepted sample and gathers LANES
// of them into one word. The first sample of a group goes to the lowest lane.
// The finished word is presented combinationally, in the same cycle as
// the sample that completes the group.
// Assumes: LANES >= 2, KEEP_W <= SAMPLE_W, clear has priority over capture.
module sp_lane_packer #(
    parameter int SAMPLE_W = 12,
    parameter int KEEP_W   = 8,
    parameter int LANES    = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clear,
    input  logic                    enable,
    input  logic                    smp_valid,
    input  logic [SAMPLE_W-1:0]     smp_data,
    output logic                    word_valid,
    output logic [LANES*KEEP_W-1:0] word_data
);
    localparam int CNT_W = $clog2(LANES);

    logic [CNT_W-1:0]  cnt_q;
    logic [KEEP_W-1:0] kept;
    logic              take;
    logic              last;

    // Select the truncated byte and decide whether this sample is captured.
    always_comb begin
        kept       = smp_data[SAMPLE_W-1 -: KEEP_W];
        take       = enable && smp_valid && !clear;
        last       = (cnt_q == CNT_W'(LANES - 1));
        word_valid = take && last;
    end

    // Count the lane position inside the current group.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt_q <= '0;
        end else if (take) begin
            cnt_q <= last ? '0 : cnt_q + 1'b1;
        end
    end

    for (genvar lane = 0; lane < LANES; lane++) begin : g_lane
        if (lane == LANES - 1) begin : g_top
            // The top lane comes straight from the completing sample.
            assign word_data[lane*KEEP_W +: KEEP_W] = kept;
        end else begin : g_reg
            logic [KEEP_W-1:0] lane_q;
            // Hold the byte captured for this lane.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    lane_q <= '0;
                end else if (take && cnt_q == CNT_W'(lane)) begin
                    lane_q <= kept;
                end
            end
            assign word_data[lane*KEEP_W +: KEEP_W] = lane_q;
        end
    end

endmodule

// File: rtl/sp_word_fifo.sv
// Module sp_word_fifo
// Show-ahead FIFO of packed words. A push is ignored when the FIFO is full,
// and the caller reports the drop. flush empties the FIFO and has priority
// over push and pop.
// Assumes: DEPTH is a power of two and at least 2; pop only when not empty.
module sp_word_fifo #(
    parameter int WIDTH = 64,
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head_data,
    output logic             empty,
    output logic             full
);
    localparam int PTR_W = $clog2(DEPTH);

    logic [WIDTH-1:0] mem_q [DEPTH];
    logic [PTR_W-1:0] wr_ptr_q;
    logic [PTR_W-1:0] rd_ptr_q;
    logic [PTR_W:0]   count_q;
    logic             do_push;
    logic             do_pop;

    // Derive the status flags and the qualified push and pop.
    always_comb begin
        empty     = (count_q == '0);
        full      = (count_q == (PTR_W+1)'(DEPTH));
        do_push   = push && !full && !flush;
        do_pop    = pop && !empty && !flush;
        head_data = mem_q[rd_ptr_q];
    end

    // Write storage; no reset is needed on the data itself.
    always_ff @(posedge clk) begin
        if (do_push) begin
            mem_q[wr_ptr_q] <= push_data;
        end
    end

    // Move the pointers and the occupancy count.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            count_q  <= '0;
        end else begin
            if (do_push) wr_ptr_q <= wr_ptr_q + 1'b1;
            if (do_pop)  rd_ptr_q <= rd_ptr_q + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count_q <= count_q + 1'b1;
                2'b01:   count_q <= count_q - 1'b1;
                default: count_q <= count_q;
            endcase
        end
    end

endmodule

// File: rtl/sp_window_seq.sv
// Module sp_window_seq
// Produces the write address inside the window [base, limit]. The address
// advances by STEP bytes on each accepted write. After the write to the
// limit, the sequencer either wraps to the base or ends the run.
// Assumes: base and limit are STEP-aligned and base <= limit.
module sp_window_seq #(
    parameter int ADDR_W = 32,
    parameter int STEP   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              wrap_en,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [ADDR_W-1:0] limit_addr,
    input  logic              accept,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [ADDR_W-1:0] win_lo,
    output logic [ADDR_W-1:0] win_hi,
    output logic              running,
    output logic              done
);
    import sp_pkg::*;

    seq_state_t        state_q;
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] lo_q;
    logic [ADDR_W-1:0] hi_q;
    logic              wrap_q;

    // Capture the window at start and step through it on each accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            addr_q  <= '0;
            lo_q    <= '0;
            hi_q    <= '0;
            wrap_q  <= 1'b0;
        end else if (start) begin
            state_q <= SEQ_RUN;
            addr_q  <= base_addr;
            lo_q    <= base_addr;
            hi_q    <= limit_addr;
            wrap_q  <= wrap_en;
        end else if (accept && state_q == SEQ_RUN) begin
            if (addr_q == hi_q) begin
                if (wrap_q) begin
                    addr_q <= lo_q;
                end else begin
                    state_q <= SEQ_DONE;
                end
            end else begin
                addr_q <= addr_q + ADDR_W'(STEP);
            end
        end
    end

    // Present the state to the top level.
    always_comb begin
        cur_addr = addr_q;
        win_lo   = lo_q;
        win_hi   = hi_q;
        running  = (state_q == SEQ_RUN);
        done     = (state_q == SEQ_DONE);
    end

endmodule

// File: rtl/sample_pack_writer.sv
// Module sample_pack_writer
// Top level. It truncates and packs converter samples into bus words,
// queues the words in a FIFO, and writes them through a memory-mapped
// master with wait-request into a bounded address window.
// Assumes: start is a single-cycle pulse; the window is word-aligned;
// outside a run, samples are ignored.
module sample_pack_writer #(
    parameter int SAMPLE_W   = 12,
    parameter int KEEP_W     = 8,
    parameter int LANES      = 8,
    parameter int ADDR_W     = 32,
    parameter int FIFO_DEPTH = 16,
    localparam int DATA_W    = LANES * KEEP_W,
    localparam int BE_W      = DATA_W / 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                wrap_en,
    input  logic [ADDR_W-1:0]   base_addr,
    input  logic [ADDR_W-1:0]   limit_addr,
    input  logic                smp_valid,
    input  logic [SAMPLE_W-1:0] smp_data,
    output logic [ADDR_W-1:0]   m_address,
    output logic [DATA_W-1:0]   m_writedata,
    output logic                m_write,
    output logic [BE_W-1:0]     m_byteenable,
    input  logic                m_waitrequest,
    output logic                done,
    output logic                overflow
);
    logic              running;
    logic              word_valid;
    logic [DATA_W-1:0] word_data;
    logic              fifo_empty;
    logic              fifo_full;
    logic              accept;
    logic [ADDR_W-1:0] win_lo;
    logic [ADDR_W-1:0] win_hi;
    logic              ovf_q;

    sp_lane_packer #(
        .SAMPLE_W (SAMPLE_W),
        .KEEP_W   (KEEP_W),
        .LANES    (LANES)
    ) u_packer (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (start),
        .enable     (running),
        .smp_valid  (smp_valid),
        .smp_data   (smp_data),
        .word_valid (word_valid),
        .word_data  (word_data)
    );

    sp_word_fifo #(
        .WIDTH (DATA_W),
        .DEPTH (FIFO_DEPTH)
    ) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (start),
        .push      (word_valid),
        .push_data (word_data),
        .pop       (accept),
        .head_data (m_writedata),
        .empty     (fifo_empty),
        .full      (fifo_full)
    );

    sp_window_seq #(
        .ADDR_W (ADDR_W),
        .STEP   (BE_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .wrap_en    (wrap_en),
        .base_addr  (base_addr),
        .limit_addr (limit_addr),
        .accept     (accept),
        .cur_addr   (m_address),
        .win_lo     (win_lo),
        .win_hi     (win_hi),
        .running    (running),
        .done       (done)
    );

    // Issue a write whenever a run is active and a word is queued.
    always_comb begin
        m_write      = running && !fifo_empty;
        accept       = m_write && !m_waitrequest;
        m_byteenable = '1;
        overflow     = ovf_q;
    end

    // Record a dropped word; only a new start clears the record.
    always_ff @(posedge clk) begin
        if (!rst_n || start) begin
            ovf_q <= 1'b0;
        end else if (word_valid && fifo_full) begin
            ovf_q <= 1'b1;
        end
    end

endmodule

// File: rtl/sp_writer_checker.sv
// Module sp_writer_checker
// Protocol and window properties of sample_pack_writer, bound to the top.
// Assumes: the top-level signal names used in the bind below.
module sp_writer_checker #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 64,
    parameter int BE_W   = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              m_write,
    input logic              m_waitrequest,
    input logic [ADDR_W-1:0] m_address,
    input logic [DATA_W-1:0] m_writedata,
    input logic [BE_W-1:0]   m_byteenable,
    input logic              done,
    input logic              overflow,
    input logic [ADDR_W-1:0] win_lo,
    input logic [ADDR_W-1:0] win_hi
);
    assert_hold_on_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (m_write && m_waitrequest && !start) |=>
            (m_write && $stable(m_address) && $stable(m_writedata)));

    assert_in_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
        m_write |-> (m_address >= win_lo && m_address <= win_hi));

    assert_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (m_write && !m_waitrequest && !start && m_address != win_hi) |=>
            (m_address == $past(m_address) + ADDR_W'(BE_W)));

    assert_stop_when_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !m_write);

    assert_sticky_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && !start) |=> overflow);

    assert_start_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (!done && !overflow && !m_write));

    assert_full_enables_R11: assert property (@(posedge clk) disable iff (!rst_n)
        m_write |-> (m_byteenable == '1));

endmodule

bind sample_pack_writer sp_writer_checker #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .BE_W   (BE_W)
) u_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (start),
    .m_write       (m_write),
    .m_waitrequest (m_waitrequest),
    .m_address     (m_address),
    .m_writedata   (m_writedata),
    .m_byteenable  (m_byteenable),
    .done          (done),
    .overflow      (overflow),
    .win_lo        (win_lo),
    .win_hi        (win_hi)
);

// File: tb/tb_sample_pack_writer.sv
module tb_sample_pack_writer;
    localparam int DEPTH = 4;
    localparam int NVEC  = 6;

    // Stimulus: eight 12-bit samples, sample 0 in bits 11:0; expected word.
    localparam logic [95:0] STIM [NVEC] = '{
        96'h088_079_06A_05B_04C_03D_02E_01F,
        96'hFFF_FFF_FFF_FFF_FFF_FFF_FFF_FFF,
        96'h00F_00F_00F_00F_00F_00F_00F_00F,
        96'h9A7_896_675_454_123_EF2_CD1_AB0,
        96'h000_000_000_000_000_000_000_800,
        96'h7F0_00F_00F_00F_00F_00F_00F_00F
    };
    localparam logic [63:0] EXPW [NVEC] = '{
        64'h0807_0605_0403_0201,
        64'hFFFF_FFFF_FFFF_FFFF,
        64'h0000_0000_0000_0000,
        64'h9A89_6745_12EF_CDAB,
        64'h0000_0000_0000_0080,
        64'h7F00_0000_0000_0000
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        wrap_en = 1'b0;
    logic [31:0] base_addr = '0;
    logic [31:0] limit_addr = '0;
    logic        smp_valid = 1'b0;
    logic [11:0] smp_data = '0;
    logic [31:0] m_address;
    logic [63:0] m_writedata;
    logic        m_write;
    logic [7:0]  m_byteenable;
    logic        m_waitrequest = 1'b0;
    logic        done;
    logic        overflow;

    int checks = 0;
    int errors = 0;
    int wr_cnt = 0;
    logic [31:0] wr_addr [64];
    logic [63:0] wr_data [64];
    bit finished = 1'b0;

    always #5 clk = ~clk;

    sample_pack_writer #(.FIFO_DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .wrap_en(wrap_en),
        .base_addr(base_addr), .limit_addr(limit_addr),
        .smp_valid(smp_valid), .smp_data(smp_data),
        .m_address(m_address), .m_writedata(m_writedata), .m_write(m_write),
        .m_byteenable(m_byteenable), .m_waitrequest(m_waitrequest),
        .done(done), .overflow(overflow)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Record every accepted write, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && m_write && !m_waitrequest) begin
            check("R11 byte enables", 64'(m_byteenable), 64'hFF);
            if (wr_cnt < 64) begin
                wr_addr[wr_cnt] = m_address;
                wr_data[wr_cnt] = m_writedata;
            end
            wr_cnt++;
        end
    end

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic do_start(input logic [31:0] b, input logic [31:0] l, input logic w);
        base_addr = b; limit_addr = l; wrap_en = w; start = 1'b1;
        tick(1);
        start = 1'b0;
    endtask

    task automatic send_samples(input logic [95:0] g, input int n);
        for (int k = 0; k < n; k++) begin
            smp_valid = 1'b1;
            smp_data  = g[k*12 +: 12];
            tick(1);
        end
        smp_valid = 1'b0;
    endtask

    task automatic wait_writes(input int n);
        for (int i = 0; i < 200 && wr_cnt < n; i++) tick(1);
    endtask

    initial begin
        int b0;
        logic [31:0] a_hold;
        logic [63:0] d_hold;
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R12: reset state and no capture before any start.
        check("R12 m_write after reset", 64'(m_write), 0);
        check("R12 done after reset", 64'(done), 0);
        check("R12 overflow after reset", 64'(overflow), 0);
        send_samples(STIM[0], 8);
        tick(5);
        check("R12 no write before start", 64'(wr_cnt), 0);

        // Table walk: R1 R2 R3 R5 R8, window of eight words, no wrap.
        do_start(32'h1000, 32'h1038, 1'b0);
        for (int v = 0; v < NVEC; v++) begin
            m_waitrequest = v[0];
            send_samples(STIM[v], 8);
            if (v[0]) begin
                tick(1);
                a_hold = m_address; d_hold = m_writedata;
                tick(3);
                check("R8 write held under stall", 64'(m_write), 1);
                check("R8 address held", 64'(m_address), 64'(a_hold));
                check("R8 data held", m_writedata, d_hold);
                m_waitrequest = 1'b0;
            end
            wait_writes(v + 1);
            check("R1 R2 packed word", wr_data[v], EXPW[v]);
            check("R5 address", 64'(wr_addr[v]), 64'(32'h1000 + 8 * v));
        end
        // R6: two more words fill the window, then the run ends.
        send_samples(STIM[3], 8);
        send_samples(STIM[0], 8);
        wait_writes(8);
        tick(2);
        check("R6 eighth address is limit", 64'(wr_addr[7]), 64'h1038);
        check("R6 done at limit", 64'(done), 1);
        send_samples(STIM[1], 8);
        tick(10);
        check("R6 no write after done", 64'(wr_cnt), 8);
        check("R6 m_write low after done", 64'(m_write), 0);

        // R7: two-word window in wrap mode.
        b0 = wr_cnt;
        do_start(32'h2000, 32'h2008, 1'b1);
        check("R10 done cleared by start", 64'(done), 0);
        send_samples(STIM[0], 8);
        send_samples(STIM[1], 8);
        send_samples(STIM[2], 8);
        wait_writes(b0 + 3);
        tick(2);
        check("R7 first address", 64'(wr_addr[b0]), 64'h2000);
        check("R7 second address", 64'(wr_addr[b0 + 1]), 64'h2008);
        check("R7 wrapped address", 64'(wr_addr[b0 + 2]), 64'h2000);
        check("R7 wrapped data", wr_data[b0 + 2], EXPW[2]);
        check("R7 done stays low", 64'(done), 0);

        // R3 R10: an incomplete group writes nothing and is discarded by start.
        b0 = wr_cnt;
        do_start(32'h3000, 32'h30F8, 1'b0);
        send_samples(STIM[3], 7);
        tick(5);
        check("R3 no write for seven samples", 64'(wr_cnt), 64'(b0));
        do_start(32'h3000, 32'h30F8, 1'b0);
        send_samples(STIM[0], 8);
        wait_writes(b0 + 1);
        check("R10 partial group discarded", wr_data[b0], EXPW[0]);
        check("R10 address after restart", 64'(wr_addr[b0]), 64'h3000);

        // R4 R9: stall, fill the FIFO, drop one word.
        b0 = wr_cnt;
        do_start(32'h4000, 32'h40F8, 1'b0);
        m_waitrequest = 1'b1;
        for (int g = 0; g < DEPTH; g++) send_samples(STIM[g], 8);
        tick(1);
        check("R9 no overflow at exactly full", 64'(overflow), 0);
        send_samples(STIM[5], 8);
        tick(1);
        check("R9 overflow set on drop", 64'(overflow), 1);
        m_waitrequest = 1'b0;
        wait_writes(b0 + DEPTH);
        tick(10);
        check("R9 dropped word not written", 64'(wr_cnt), 64'(b0 + DEPTH));
        check("R9 overflow sticky", 64'(overflow), 1);
        for (int g = 0; g < DEPTH; g++)
            check("R4 FIFO order", wr_data[b0 + g], EXPW[g]);
        do_start(32'h4000, 32'h40F8, 1'b0);
        check("R10 overflow cleared by start", 64'(overflow), 0);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule